// File: doc/BRIEF.md
# Triggered Pixel Hit Latency Buffer

This block sits beside a small group of pixels and holds each pixel hit until the level-1 trigger decision for that hit's bunch crossing is known. A hit on any line of the group is turned into an 8-bit local address code. The code is written, together with the current timestamp, into one of four identical buffer cells. The group is either 8 pixels, where each pixel owns one address bit, or 16 pixels, where each pixel is given a unique pair of bits.

Each cell runs a small state machine with three states: `CELL_FREE`, `CELL_WAIT` and `CELL_READY`. A write takes a free cell to `CELL_WAIT` (transition ALLOC). A waiting cell is due in the cycle when its stored timestamp equals the current timestamp minus the programmed latency, with 11-bit wrapping arithmetic. If the trigger is high in that cycle, the cell moves to `CELL_READY` (transition KEEP). If the trigger is low, the cell returns to `CELL_FREE` (transition DROP). A ready cell offers its address and timestamp on a valid/ready port. It returns to `CELL_FREE` at the edge where the data is accepted (transition SENT).

When all four cells are busy, an incoming hit is lost and a saturating overflow counter counts it. The programmed latency must be at least 1. A latency of 1000 covers 25 us at a 40 MHz timestamp.

Top module: `trig_hit_buffer`

## Requirements
- R1: After reset, `rd_valid` is 0, `ovf_count` is 0 and all four cells are free.
- R2: With `group16`=0, pixel line i (0..7) sets address bit i, so a single hit gives a one-hot code. Lines 8..15 are ignored: they allocate no cell and do not count as overflow.
- R3: With `group16`=1, pixel line i (0..15) sets bit i/4 (the row, in bits 3..0) and bit 4+i%4 (the column, in bits 7..4).
- R4: In a cycle where the address code is non-zero, the code and `ts_now` are written at the next clock edge into the lowest-index free cell.
- R5: A hit that arrives while no cell is free is lost. `ovf_count` then increases by one and saturates at 255.
- R6: A waiting cell is due in the cycle where `ts_now - latency` equals its stored timestamp. If `l1_trig` is high in that cycle, the cell becomes ready. If it is low, the cell is freed and never appears on the read port. A trigger in any other cycle has no effect on the cell.
- R7: The read port presents the lowest-index ready cell, regardless of the cell's age. `rd_valid` stays high until `rd_ready` is seen.
- R8: A cell whose data is accepted is free from the next cycle. A hit in that cycle is stored in it and does not count as overflow.
- R9: The due compare wraps modulo 2048, so a hit stored near the top of the timestamp range becomes due after the timestamp wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| group16 | input | 1 | 0: 8-pixel group, 1: 16-pixel group |
| pix_hit | input | 16 | Pixel hit lines |
| ts_now | input | 11 | Current timestamp |
| latency | input | 11 | Trigger latency in timestamp ticks (at least 1) |
| l1_trig | input | 1 | Level-1 trigger |
| rd_valid | output | 1 | A ready cell is offered |
| rd_ready | input | 1 | Consumer accepts the offered cell |
| rd_addr | output | 8 | Address code of the offered cell |
| rd_ts | output | 11 | Timestamp of the offered cell |
| ovf_count | output | 8 | Saturating count of lost hits |

## Verification
The main function is tried with a table of single hits: corner pixels and middle pixels in both group sizes. Each hit gets its own latency, so a wrong code bit or a wrong due cycle shows up as a wrong address or a wrong timestamp. A burst of five hits in five cycles tells allocation order apart from overflow handling. A mix of dropped and kept cells, with a newer hit placed in the lowest cell, tells index priority apart from age order. A trigger one cycle early and a due time that crosses the timestamp wrap tell the exact due compare apart from near-misses. The ignored upper lines in 8-pixel mode and the reuse of a cell right after acceptance are checked at the read port and at the overflow count.

// File: rtl/hitbuf_pkg.sv
package hitbuf_pkg;
    localparam int ADDR_W = 8;
    localparam int PIX_N  = 2 * ADDR_W;
    localparam int HALF_W = ADDR_W / 2;

    typedef enum logic [1:0] {
        CELL_FREE  = 2'd0,
        CELL_WAIT  = 2'd1,
        CELL_READY = 2'd2
    } cell_st_t;
endpackage

// File: rtl/hitbuf_addr_enc.sv
module hitbuf_addr_enc
    import hitbuf_pkg::*;
(
    input  logic              group16,
    input  logic [PIX_N-1:0]  pix_hit,
    output logic [ADDR_W-1:0] code,
    output logic              hit
);
    always_comb begin
        code = '0;
        if (!group16) begin
            code = pix_hit[ADDR_W-1:0];
        end else begin
            for (int i = 0; i < PIX_N; i++) begin
                if (pix_hit[i]) begin
                    code[i / HALF_W]            = 1'b1;
                    code[HALF_W + (i % HALF_W)] = 1'b1;
                end
            end
        end
        hit = |code;
    end
endmodule

// File: rtl/hitbuf_pick.sv
module hitbuf_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
        any = |req;
    end
endmodule

// File: rtl/hitbuf_cell.sv
module hitbuf_cell
    import hitbuf_pkg::*;
#(
    parameter int TS_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_code,
    input  logic [TS_W-1:0]   wr_ts,
    input  logic [TS_W-1:0]   due_ts,
    input  logic              l1_trig,
    input  logic              rd_take,
    output logic              is_free,
    output logic              is_ready,
    output logic [ADDR_W-1:0] out_code,
    output logic [TS_W-1:0]   out_ts
);
    cell_st_t          st_q, st_d;
    logic [ADDR_W-1:0] code_q;
    logic [TS_W-1:0]   ts_q;
    logic              due;

    assign due = (ts_q == due_ts);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CELL_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CELL_FREE:  if (wr_en) st_d = CELL_WAIT;
            CELL_WAIT:  if (due)   st_d = l1_trig ? CELL_READY : CELL_FREE;
            CELL_READY: if (rd_take) st_d = CELL_FREE;
            default:    st_d = CELL_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            ts_q   <= '0;
        end else if (wr_en && st_q == CELL_FREE) begin
            code_q <= wr_code;
            ts_q   <= wr_ts;
        end
    end

    always_comb begin
        is_free  = (st_q == CELL_FREE);
        is_ready = (st_q == CELL_READY);
        out_code = code_q;
        out_ts   = ts_q;
    end
endmodule

// File: rtl/trig_hit_buffer.sv
module trig_hit_buffer
    import hitbuf_pkg::*;
#(
    parameter int TS_W  = 11,
    parameter int OVF_W = 8,
    parameter int NCELL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              group16,
    input  logic [PIX_N-1:0]  pix_hit,
    input  logic [TS_W-1:0]   ts_now,
    input  logic [TS_W-1:0]   latency,
    input  logic              l1_trig,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [TS_W-1:0]   rd_ts,
    output logic [OVF_W-1:0]  ovf_count
);
    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    logic [ADDR_W-1:0] code;
    logic              hit;
    logic [TS_W-1:0]   due_ts;
    logic [NCELL-1:0]  free_v, ready_v, alloc_g, rd_g, wr_en, take;
    logic              any_free, any_ready;
    logic [ADDR_W-1:0] cell_code [NCELL];
    logic [TS_W-1:0]   cell_ts   [NCELL];

    assign due_ts = ts_now - latency;

    hitbuf_addr_enc u_enc (
        .group16 (group16),
        .pix_hit (pix_hit),
        .code    (code),
        .hit     (hit)
    );

    hitbuf_pick #(.N(NCELL)) u_alloc (
        .req (free_v),
        .gnt (alloc_g),
        .any (any_free)
    );

    hitbuf_pick #(.N(NCELL)) u_rdsel (
        .req (ready_v),
        .gnt (rd_g),
        .any (any_ready)
    );

    assign wr_en = alloc_g & {NCELL{hit}};
    assign take  = rd_g & {NCELL{any_ready && rd_ready}};

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        hitbuf_cell #(.TS_W(TS_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[g]),
            .wr_code  (code),
            .wr_ts    (ts_now),
            .due_ts   (due_ts),
            .l1_trig  (l1_trig),
            .rd_take  (take[g]),
            .is_free  (free_v[g]),
            .is_ready (ready_v[g]),
            .out_code (cell_code[g]),
            .out_ts   (cell_ts[g])
        );
    end

    always_comb begin
        rd_valid = any_ready;
        rd_addr  = '0;
        rd_ts    = '0;
        for (int i = 0; i < NCELL; i++) begin
            if (rd_g[i]) begin
                rd_addr = rd_addr | cell_code[i];
                rd_ts   = rd_ts | cell_ts[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovf_count <= '0;
        else if (hit && !any_free && ovf_count != OVF_MAX)
            ovf_count <= ovf_count + 1'b1;
    end
endmodule

// File: rtl/hitbuf_chk.sv
module hitbuf_chk #(
    parameter int TS_W  = 11,
    parameter int OVF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      pix_hit,
    input logic             l1_trig,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [TS_W-1:0]  rd_ts,
    input logic [OVF_W-1:0] ovf_count
);
    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid); // R7
    AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_count == OVF_MAX |=> ovf_count == OVF_MAX); // R5
    AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_count != $past(ovf_count) |-> ovf_count == $past(ovf_count) + 1'b1); // R5
    AST_OVF_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_count != $past(ovf_count) |-> $past(|pix_hit)); // R5
    AST_READY_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(l1_trig)); // R6
endmodule

bind trig_hit_buffer hitbuf_chk #(.TS_W(TS_W), .OVF_W(OVF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_hit   (pix_hit),
    .l1_trig   (l1_trig),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_ts     (rd_ts),
    .ovf_count (ovf_count)
);

// File: tb/sim_trig_hit_buffer.sv
module sim_trig_hit_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        group16 = 1'b0;
    logic [15:0] pix_hit = '0;
    logic [10:0] ts_now = '0;
    logic [10:0] latency = 11'd4;
    logic        l1_trig = 1'b0;
    logic        rd_ready = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_addr;
    logic [10:0] rd_ts;
    logic [7:0]  ovf_count;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    trig_hit_buffer u0 (
        .clk(clk), .rst_n(rst_n), .group16(group16), .pix_hit(pix_hit),
        .ts_now(ts_now), .latency(latency), .l1_trig(l1_trig),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_ts(rd_ts), .ovf_count(ovf_count)
    );

    // {group16, pixel, expected code}
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 4'd0,  8'h01}, {1'b0, 4'd7,  8'h80},
        {1'b0, 4'd3,  8'h08}, {1'b1, 4'd0,  8'h11},
        {1'b1, 4'd5,  8'h22}, {1'b1, 4'd10, 8'h44},
        {1'b1, 4'd15, 8'h88}, {1'b1, 4'd12, 8'h18}
    };

    task automatic step();
        @(posedge clk);
        #2;
        ts_now = ts_now + 1'b1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pix_hit = '0; l1_trig = 1'b0; rd_ready = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic hit_one(input int pix, output logic [10:0] t);
        t = ts_now;
        pix_hit = 16'd1 << pix;
        step();
        pix_hit = '0;
    endtask

    task automatic wait_until(input logic [10:0] tgt);
        while (ts_now != tgt) step();
    endtask

    task automatic expire(input logic [10:0] tgt, input logic trig);
        wait_until(tgt);
        l1_trig = trig;
        step();
        l1_trig = 1'b0;
    endtask

    task automatic read_one(input string tag, input logic [7:0] ea, input logic [10:0] et);
        chk({tag, " valid"}, rd_valid, 1);
        chk({tag, " addr"}, rd_addr, ea);
        chk({tag, " ts"}, rd_ts, et);
        rd_ready = 1'b1;
        step();
        rd_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [10:0] t, t0, tb;
        #1;
        do_reset();
        // R1
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 ovf", ovf_count, 0);

        // table walk: R2 R3 R4 R6
        for (int v = 0; v < 8; v++) begin
            group16 = VEC[v][12];
            latency = 11'(2 + v);
            hit_one(int'(VEC[v][11:8]), t);
            expire(t + latency, 1'b1);
            read_one($sformatf("R3 R2 vec%0d", v), VEC[v][7:0], t);
            chk("R6 empty after read", rd_valid, 0);
        end

        // R2: upper lines ignored in 8-pixel mode
        group16 = 1'b0; latency = 11'd3;
        hit_one(12, t);
        expire(t + latency, 1'b1);
        chk("R2 ignored line valid", rd_valid, 0);
        chk("R2 ignored line ovf", ovf_count, 0);

        // R4 R5 R6 R7: allocation, overflow, drop, index priority
        latency = 11'd20;
        t0 = ts_now;
        for (int k = 0; k < 5; k++) begin
            pix_hit = 16'd1 << k;
            step();
        end
        pix_hit = '0;
        chk("R5 ovf after burst", ovf_count, 1);
        expire(t0 + 11'd20, 1'b0);
        chk("R6 dropped cell", rd_valid, 0);
        tb = ts_now;
        l1_trig = 1'b1;
        pix_hit = 16'd1 << 5;
        step();
        pix_hit = '0;
        step(); step();
        l1_trig = 1'b0;
        chk("R7 first ready", rd_addr, 8'h02);
        step(); step(); step();
        chk("R7 valid held", rd_valid, 1);
        chk("R7 data held", rd_addr, 8'h02);
        expire(tb + 11'd20, 1'b1);
        read_one("R7 lowest idx c0", 8'h20, tb);
        read_one("R4 c1", 8'h02, t0 + 11'd1);
        read_one("R4 c2", 8'h04, t0 + 11'd2);
        read_one("R4 c3", 8'h08, t0 + 11'd3);
        chk("R7 drained", rd_valid, 0);

        // R5 saturation
        latency = 11'd1000;
        pix_hit = 16'h0001;
        repeat (304) step();
        pix_hit = '0;
        chk("R5 saturated", ovf_count, 255);
        do_reset();
        chk("R1 ovf after reset", ovf_count, 0);
        chk("R1 valid after reset", rd_valid, 0);

        // R8 reuse after accept
        latency = 11'd10;
        t0 = ts_now;
        for (int k = 0; k < 4; k++) begin
            pix_hit = 16'd1 << k;
            step();
        end
        pix_hit = '0;
        l1_trig = 1'b1;
        wait_until(t0 + 11'd14);
        l1_trig = 1'b0;
        read_one("R8 c0", 8'h01, t0);
        hit_one(6, tb);
        chk("R8 no overflow", ovf_count, 0);
        read_one("R8 c1", 8'h02, t0 + 11'd1);
        read_one("R8 c2", 8'h04, t0 + 11'd2);
        read_one("R8 c3", 8'h08, t0 + 11'd3);
        expire(tb + latency, 1'b1);
        read_one("R8 reused c0", 8'h40, tb);

        // R6: trigger one cycle early has no effect
        latency = 11'd6;
        hit_one(1, t);
        wait_until(t + latency - 11'd1);
        l1_trig = 1'b1;
        step();
        l1_trig = 1'b0;
        step();
        chk("R6 early trigger", rd_valid, 0);

        // R9 wrap
        group16 = 1'b1; latency = 11'd5;
        ts_now = 11'd2045;
        hit_one(2, t);
        wait_until(11'd1);
        chk("R9 not yet due", rd_valid, 0);
        expire(11'd2, 1'b1);
        read_one("R9 wrap", 8'h41, 11'd2045);

        finish_run();
    end
endmodule